// File: doc/BRIEF.md
# 8-bit ALU with Condition Codes

This block is a purely combinational arithmetic/logic unit for an 8-bit processor datapath that also carries a 16-bit add, subtract and compare path. Each cycle it takes a 5-bit operation code, two 16-bit operand buses and the current 8-bit condition-code byte. It returns a 16-bit result and the updated condition-code byte. Eight-bit operations read only the low byte of each operand and return zero in the upper result byte. Operand fetch, register writeback and any decision on whether to write the result belong to the surrounding datapath.

The condition-code byte is laid out as: bit 0 carry (C), bit 1 overflow (V), bit 2 zero (Z), bit 3 negative (N), bit 4 interrupt mask (I), bit 5 half carry (H), bit 6 fast-interrupt mask (F), bit 7 entire-state (E). Each operation touches its own set of flags. Every flag it does not name passes through from `cc_in` unchanged.

Top module: `alu8_cc`

## Requirements
- R1: Bits 7, 6 and 4 of `cc_out` always equal those of `cc_in`. For 8-bit operations `result[15:8]` is 0. Opcodes 26 to 31 are unused: they give `result` = 0 and `cc_out` = `cc_in`.
- R2: Add (op 0) and add-with-carry (op 1, carry-in = `cc_in` bit 0) return the 8-bit sum of `opa[7:0]` and `opb[7:0]`. H is the carry out of the low-nibble sum, carry-in included. C is the carry out of bit 7. V is signed overflow. N and Z follow the sum.
- R3: Subtract (op 2), subtract-with-borrow (op 3, borrow-in = `cc_in` bit 0) and compare (op 4) form `opa[7:0]` - `opb[7:0]` (- borrow-in). C is the unsigned borrow, V is signed overflow, N and Z follow the difference, and H is unchanged. Compare returns `opa[7:0]` as its result.
- R4: AND (op 5), OR (op 6), XOR (op 7), bit test (op 8) and load (op 25, which passes `opb[7:0]`) clear V and set N and Z from the logic value. C and H are unchanged. Bit test returns `opa[7:0]`.
- R5: Negate (op 9) returns the two's complement of `opa[7:0]`. It sets V only for 0x80 and sets C whenever the operand is nonzero.
- R6: Complement (op 10) returns the bitwise inverse with C = 1 and V = 0. Clear (op 13) returns 0 with Z = 1 and N = V = C = 0. Test (op 14) returns the operand with V = 0 and C unchanged. All three set N and Z from their result.
- R7: Increment (op 11) sets V only for operand 0x7F. Decrement (op 12) sets V only for operand 0x80. Neither changes C.
- R8: Logical right shift (op 15) moves bit 0 into C and gives N = 0. Arithmetic right shift (op 16) keeps bit 7 and moves bit 0 into C. Left shift (op 17) moves bit 7 into C and sets V = bit 7 XOR bit 6 of the operand. The right shifts leave V unchanged.
- R9: Rotate right (op 18) shifts C into bit 7 and bit 0 into C. Rotate left (op 19) shifts C into bit 0, bit 7 into C, and sets V = bit 7 XOR bit 6 of the operand. Both set N and Z.
- R10: Decimal adjust (op 20) works on `opa[7:0]`. It adds 0x06 when H is set or the low nibble is above 9. It adds 0x60 when C is set, the high nibble is above 9, or the high nibble is above 8 while the low nibble is above 9. When both hold it adds 0x66. C is set exactly when 0x60 was added. V and H are unchanged, and N and Z follow the result.
- R11: Multiply (op 21) returns the 16-bit unsigned product of `opa[7:0]` and `opb[7:0]`. It sets Z when the product is zero and copies product bit 7 into C. N, V and H are unchanged.
- R12: The 16-bit add (op 22), subtract (op 23) and compare (op 24) operate on the full operands. C is the carry (or unsigned borrow), V is signed overflow, N is bit 15 and Z covers 16 bits. H is unchanged. The 16-bit compare returns `opa`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code (values listed in the requirements) |
| opa | input | 16 | First operand (destination side); 8-bit operations use bits 7:0 |
| opb | input | 16 | Second operand; 8-bit operations use bits 7:0 |
| cc_in | input | 8 | Current condition-code byte |
| result | output | 16 | Operation result |
| cc_out | output | 8 | Updated condition-code byte |

## Verification
Every output of this block is a function of the present inputs only, so each result and flag byte is due in the same cycle as the stimulus, with zero register stages. The bench changes all four inputs together just after a rising clock edge. It compares `result` and `cc_out` at the following falling edge, half a period later, when the logic has long settled and no edge is near. Each vector sets the flag bits that must pass through to values that would expose a wrongly updated flag.

// File: rtl/alu8_cc.sv
module alu8_cc (
  input  logic [4:0]  op,
  input  logic [15:0] opa,
  input  logic [15:0] opb,
  input  logic [7:0]  cc_in,
  output logic [15:0] result,
  output logic [7:0]  cc_out
);
  localparam logic [4:0] OP_ADD   = 5'd0,  OP_ADC   = 5'd1,  OP_SUB   = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CMP   = 5'd4,  OP_AND   = 5'd5,  OP_OR    = 5'd6,  OP_XOR = 5'd7;
  localparam logic [4:0] OP_BIT   = 5'd8,  OP_NEG   = 5'd9,  OP_COM   = 5'd10, OP_INC = 5'd11;
  localparam logic [4:0] OP_DEC   = 5'd12, OP_CLR   = 5'd13, OP_TST   = 5'd14, OP_LSR = 5'd15;
  localparam logic [4:0] OP_ASR   = 5'd16, OP_LSL   = 5'd17, OP_ROR   = 5'd18, OP_ROL = 5'd19;
  localparam logic [4:0] OP_DAA   = 5'd20, OP_MUL   = 5'd21, OP_ADDW  = 5'd22, OP_SUBW = 5'd23;
  localparam logic [4:0] OP_CMPW  = 5'd24, OP_LD    = 5'd25;
  localparam int CB = 0, VB = 1, ZB = 2, NB = 3, HB = 5;

  logic [7:0] a, b;
  logic       cin;
  assign a   = opa[7:0];
  assign b   = opb[7:0];
  assign cin = cc_in[CB];

  // shared 8-bit adder: subtraction as a + ~b + 1 (or + 0 with borrow-in)
  logic       sub8, chain8, c0;
  logic [7:0] be;
  logic [8:0] sum9;
  logic [4:0] nib;
  logic       v8;
  assign sub8   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign chain8 = (op == OP_ADC) || (op == OP_SBC);
  assign be     = sub8 ? ~b : b;
  assign c0     = sub8 ? ~(chain8 & cin) : (chain8 & cin);
  assign sum9   = {1'b0, a} + {1'b0, be} + {8'd0, c0};
  assign nib    = {1'b0, a[3:0]} + {1'b0, be[3:0]} + {4'd0, c0};
  assign v8     = (a[7] == be[7]) && (sum9[7] != a[7]);

  // 16-bit adder
  logic        sub16;
  logic [15:0] bw;
  logic [16:0] sum17;
  logic        v16;
  assign sub16 = (op == OP_SUBW) || (op == OP_CMPW);
  assign bw    = sub16 ? ~opb : opb;
  assign sum17 = {1'b0, opa} + {1'b0, bw} + {16'd0, sub16};
  assign v16   = (opa[15] == bw[15]) && (sum17[15] != opa[15]);

  // decimal adjust
  logic       lo_fix, hi_fix;
  logic [7:0] daa_res;
  assign lo_fix  = cc_in[HB] || (a[3:0] > 4'd9);
  assign hi_fix  = cin || (a[7:4] > 4'd9) || ((a[7:4] > 4'd8) && (a[3:0] > 4'd9));
  assign daa_res = a + {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};

  logic [15:0] prod;
  assign prod = {8'd0, a} * {8'd0, b};

  logic [7:0] r8;
  logic       nz8, keep_a;

  always_comb begin
    r8     = 8'h00;
    nz8    = 1'b1;
    keep_a = 1'b0;
    result = 16'h0000;
    cc_out = cc_in;
    case (op)
      OP_ADD, OP_ADC: begin
        r8         = sum9[7:0];
        cc_out[HB] = nib[4];
        cc_out[CB] = sum9[8];
        cc_out[VB] = v8;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        r8         = sum9[7:0];
        cc_out[CB] = ~sum9[8];
        cc_out[VB] = v8;
        keep_a     = (op == OP_CMP);
      end
      OP_AND: begin r8 = a & b; cc_out[VB] = 1'b0; end
      OP_OR:  begin r8 = a | b; cc_out[VB] = 1'b0; end
      OP_XOR: begin r8 = a ^ b; cc_out[VB] = 1'b0; end
      OP_BIT: begin r8 = a & b; cc_out[VB] = 1'b0; keep_a = 1'b1; end
      OP_LD:  begin r8 = b;     cc_out[VB] = 1'b0; end
      OP_NEG: begin
        r8         = 8'h00 - a;
        cc_out[VB] = (a == 8'h80);
        cc_out[CB] = (a != 8'h00);
      end
      OP_COM: begin r8 = ~a; cc_out[VB] = 1'b0; cc_out[CB] = 1'b1; end
      OP_INC: begin r8 = a + 8'h01; cc_out[VB] = (a == 8'h7F); end
      OP_DEC: begin r8 = a - 8'h01; cc_out[VB] = (a == 8'h80); end
      OP_CLR: begin r8 = 8'h00; cc_out[VB] = 1'b0; cc_out[CB] = 1'b0; end
      OP_TST: begin r8 = a; cc_out[VB] = 1'b0; end
      OP_LSR: begin r8 = {1'b0, a[7:1]}; cc_out[CB] = a[0]; end
      OP_ASR: begin r8 = {a[7], a[7:1]}; cc_out[CB] = a[0]; end
      OP_LSL: begin r8 = {a[6:0], 1'b0}; cc_out[CB] = a[7]; cc_out[VB] = a[7] ^ a[6]; end
      OP_ROR: begin r8 = {cin, a[7:1]};  cc_out[CB] = a[0]; end
      OP_ROL: begin r8 = {a[6:0], cin};  cc_out[CB] = a[7]; cc_out[VB] = a[7] ^ a[6]; end
      OP_DAA: begin r8 = daa_res; cc_out[CB] = hi_fix; end
      OP_MUL: begin
        nz8        = 1'b0;
        result     = prod;
        cc_out[ZB] = (prod == 16'h0000);
        cc_out[CB] = prod[7];
      end
      OP_ADDW, OP_SUBW, OP_CMPW: begin
        nz8        = 1'b0;
        result     = (op == OP_CMPW) ? opa : sum17[15:0];
        cc_out[NB] = sum17[15];
        cc_out[ZB] = (sum17[15:0] == 16'h0000);
        cc_out[VB] = v16;
        cc_out[CB] = sub16 ? ~sum17[16] : sum17[16];
      end
      default: nz8 = 1'b0;
    endcase
    if (nz8) begin
      result     = {8'h00, keep_a ? a : r8};
      cc_out[NB] = r8[7];
      cc_out[ZB] = (r8 == 8'h00);
    end
  end
endmodule

// File: rtl/alu8_cc_chk.sv
module alu8_cc_chk (
  input logic [4:0]  op,
  input logic [15:0] opa,
  input logic [15:0] opb,
  input logic [7:0]  cc_in,
  input logic [15:0] result,
  input logic [7:0]  cc_out
);
  logic known;
  assign known = !$isunknown({op, opa, opb, cc_in});

  always_comb begin
    if (known) begin
      // R1
      keep_mask_bits_chk: assert (cc_out[7:6] == cc_in[7:6] && cc_out[4] == cc_in[4]);
      // R3
      cmp_returns_a_chk: assert (op != 5'd4 || result == {8'h00, opa[7:0]});
      // R4
      logic_v_clear_chk: assert (!(op inside {5'd5, 5'd6, 5'd7, 5'd8, 5'd25}) || !cc_out[1]);
      // R5
      neg_carry_chk: assert (op != 5'd9 || cc_out[0] == (opa[7:0] != 8'h00));
      // R7
      incdec_carry_chk: assert (!(op inside {5'd11, 5'd12}) || cc_out[0] == cc_in[0]);
      // R8
      lsr_n_zero_chk: assert (op != 5'd15 || !cc_out[3]);
      // R11
      mul_zero_chk: assert (op != 5'd21 || cc_out[2] == (opa[7:0] == 8'h00 || opb[7:0] == 8'h00));
      // R12
      cmpw_returns_a_chk: assert (op != 5'd24 || result == opa);
    end
  end
endmodule

bind alu8_cc alu8_cc_chk chk (.*);

// File: tb/tb_alu8_cc.sv
`timescale 1ns/1ps
module tb_alu8_cc;
  localparam logic [4:0] K_ADD = 5'd0, K_ADC = 5'd1, K_SUB = 5'd2, K_SBC = 5'd3, K_CMP = 5'd4;
  localparam logic [4:0] K_AND = 5'd5, K_OR = 5'd6, K_XOR = 5'd7, K_BIT = 5'd8, K_NEG = 5'd9;
  localparam logic [4:0] K_COM = 5'd10, K_INC = 5'd11, K_DEC = 5'd12, K_CLR = 5'd13, K_TST = 5'd14;
  localparam logic [4:0] K_LSR = 5'd15, K_ASR = 5'd16, K_LSL = 5'd17, K_ROR = 5'd18, K_ROL = 5'd19;
  localparam logic [4:0] K_DAA = 5'd20, K_MUL = 5'd21, K_ADDW = 5'd22, K_SUBW = 5'd23;
  localparam logic [4:0] K_CMPW = 5'd24, K_LD = 5'd25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]  op = 5'd31;
  logic [15:0] opa = 16'h0000, opb = 16'h0000;
  logic [7:0]  cc_in = 8'h00;
  logic [15:0] result;
  logic [7:0]  cc_out;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  alu8_cc dut (.op(op), .opa(opa), .opb(opb), .cc_in(cc_in), .result(result), .cc_out(cc_out));

  task automatic apply(input logic [4:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic [7:0] c, input logic [15:0] er, input logic [7:0] ec,
                       input string tag);
    @(posedge clk);
    op = o; opa = x; opb = y; cc_in = c;
    @(negedge clk);
    checks++;
    if (result !== er || cc_out !== ec) begin
      fails++;
      $display("FAIL %s op=%0d: result %h cc %h, expected result %h cc %h",
               tag, o, result, cc_out, er, ec);
    end
  endtask

  task automatic t_idle;
    apply(5'd31, 16'h1234, 16'h5678, 8'hD5, 16'h0000, 8'hD5, "R1 unused op");
    apply(5'd26, 16'hFFFF, 16'hFFFF, 8'h2A, 16'h0000, 8'h2A, "R1 unused op");
  endtask

  task automatic t_add;
    apply(K_ADD, 16'hAB0F, 16'hCD01, 8'h00, 16'h0010, 8'h20, "R2 half carry, R1 upper byte");
    apply(K_ADD, 16'h007F, 16'h0001, 8'hD0, 16'h0080, 8'hFA, "R2 overflow, R1 mask bits");
    apply(K_ADD, 16'h00FF, 16'h0001, 8'h00, 16'h0000, 8'h25, "R2 carry and zero");
    apply(K_ADC, 16'h0008, 16'h0007, 8'h01, 16'h0010, 8'h20, "R2 carry-in into nibble");
    apply(K_ADC, 16'h007F, 16'h0000, 8'h01, 16'h0080, 8'h2A, "R2 carry-in overflow");
  endtask

  task automatic t_sub;
    apply(K_SUB, 16'h0010, 16'h0020, 8'h20, 16'h00F0, 8'h29, "R3 borrow, H kept");
    apply(K_SUB, 16'h0080, 16'h0001, 8'h00, 16'h007F, 8'h02, "R3 overflow");
    apply(K_SBC, 16'h0000, 16'h0000, 8'h01, 16'h00FF, 8'h09, "R3 borrow-in");
    apply(K_CMP, 16'h0005, 16'h0005, 8'h0F, 16'h0005, 8'h04, "R3 compare equal");
    apply(K_CMP, 16'h0001, 16'h0002, 8'h00, 16'h0001, 8'h09, "R3 compare lower");
  endtask

  task automatic t_logic;
    apply(K_AND, 16'h00F0, 16'h000F, 8'h23, 16'h0000, 8'h25, "R4 and");
    apply(K_OR,  16'h0080, 16'h0001, 8'h02, 16'h0081, 8'h08, "R4 or");
    apply(K_XOR, 16'h00FF, 16'h000F, 8'h01, 16'h00F0, 8'h09, "R4 xor");
    apply(K_BIT, 16'h0055, 16'h00AA, 8'h00, 16'h0055, 8'h04, "R4 bit test");
    apply(K_LD,  16'h0077, 16'h0000, 8'h0A, 16'h0000, 8'h04, "R4 load");
  endtask

  task automatic t_unary;
    apply(K_NEG, 16'h0080, 16'h0000, 8'h00, 16'h0080, 8'h0B, "R5 negate 0x80");
    apply(K_NEG, 16'h0000, 16'h0000, 8'h03, 16'h0000, 8'h04, "R5 negate zero");
    apply(K_NEG, 16'h0001, 16'h0000, 8'h00, 16'h00FF, 8'h09, "R5 negate one");
    apply(K_COM, 16'h0000, 16'h0000, 8'h02, 16'h00FF, 8'h09, "R6 complement");
    apply(K_CLR, 16'h0055, 16'h0000, 8'hEB, 16'h0000, 8'hE4, "R6 clear");
    apply(K_TST, 16'h0080, 16'h0000, 8'h03, 16'h0080, 8'h09, "R6 test");
    apply(K_INC, 16'h007F, 16'h0000, 8'h01, 16'h0080, 8'h0B, "R7 increment 0x7F");
    apply(K_INC, 16'h00FF, 16'h0000, 8'h00, 16'h0000, 8'h04, "R7 increment wrap");
    apply(K_DEC, 16'h0080, 16'h0000, 8'h00, 16'h007F, 8'h02, "R7 decrement 0x80");
    apply(K_DEC, 16'h0000, 16'h0000, 8'h01, 16'h00FF, 8'h09, "R7 decrement wrap");
  endtask

  task automatic t_shift;
    apply(K_LSR, 16'h0081, 16'h0000, 8'h0A, 16'h0040, 8'h03, "R8 lsr");
    apply(K_LSR, 16'h0001, 16'h0000, 8'h00, 16'h0000, 8'h05, "R8 lsr to zero");
    apply(K_ASR, 16'h0081, 16'h0000, 8'h00, 16'h00C0, 8'h09, "R8 asr sign");
    apply(K_LSL, 16'h00C0, 16'h0000, 8'h00, 16'h0080, 8'h09, "R8 lsl no overflow");
    apply(K_LSL, 16'h0040, 16'h0000, 8'h00, 16'h0080, 8'h0A, "R8 lsl overflow");
    apply(K_ROR, 16'h0001, 16'h0000, 8'h01, 16'h0080, 8'h09, "R9 ror carry in");
    apply(K_ROR, 16'h0002, 16'h0000, 8'h00, 16'h0001, 8'h00, "R9 ror plain");
    apply(K_ROL, 16'h0080, 16'h0000, 8'h00, 16'h0000, 8'h07, "R9 rol carry out");
    apply(K_ROL, 16'h0001, 16'h0000, 8'h01, 16'h0003, 8'h00, "R9 rol carry in");
  endtask

  task automatic t_daa;
    apply(K_DAA, 16'h000A, 16'h0000, 8'h00, 16'h0010, 8'h00, "R10 low fix");
    apply(K_DAA, 16'h009A, 16'h0000, 8'h00, 16'h0000, 8'h05, "R10 both fixes");
    apply(K_DAA, 16'h0012, 16'h0000, 8'h20, 16'h0018, 8'h20, "R10 H forces low fix");
    apply(K_DAA, 16'h0025, 16'h0000, 8'h01, 16'h0085, 8'h09, "R10 C forces high fix");
    apply(K_DAA, 16'h00A0, 16'h0000, 8'h00, 16'h0000, 8'h05, "R10 high nibble above 9");
  endtask

  task automatic t_mul;
    apply(K_MUL, 16'h0010, 16'h0010, 8'h0E, 16'h0100, 8'h0A, "R11 product 0x0100");
    apply(K_MUL, 16'h00FF, 16'h00FF, 8'h00, 16'hFE01, 8'h00, "R11 max product");
    apply(K_MUL, 16'h000C, 16'h000B, 8'h00, 16'h0084, 8'h01, "R11 bit 7 to C");
    apply(K_MUL, 16'h0000, 16'h0055, 8'h01, 16'h0000, 8'h04, "R11 zero product");
  endtask

  task automatic t_wide;
    apply(K_ADDW, 16'h7FFF, 16'h0001, 8'h00, 16'h8000, 8'h0A, "R12 add overflow");
    apply(K_ADDW, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 8'h05, "R12 add carry");
    apply(K_SUBW, 16'h0000, 16'h0001, 8'h00, 16'hFFFF, 8'h09, "R12 sub borrow");
    apply(K_SUBW, 16'h8000, 16'h0001, 8'h00, 16'h7FFF, 8'h02, "R12 sub overflow");
    apply(K_CMPW, 16'h1234, 16'h1234, 8'h20, 16'h1234, 8'h24, "R12 compare equal");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (result !== 16'h0000 || cc_out !== 8'h00) begin
      fails++;
      $display("FAIL R1 idle after reset: result %h cc %h, expected result 0000 cc 00", result, cc_out);
    end
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_unary();
    t_shift();
    t_daa();
    t_mul();
    t_wide();
    finish_run();
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end
endmodule